// File: doc/BRIEF.md
# Control Port Command Decoder

This block takes the 16-bit words written to a video processor's control port. It keeps the access address and the 6-bit command code that later data-port accesses use. Each word carries address and command bits. The block tracks whether the next control word is the first or the second half of a two-word command. It also spots words that program an internal register, checks the register index against a limit set by the operating mode, and writes the register file.

The decoder holds a 24-entry register file of 8-bit registers. One bit of that file, bit 2 of register 1, selects the extended mode and is fed back into the index check. The block also holds four handshake flags. Three of them (fetched, read-pending, byte-pending) are set by neighbouring logic through set inputs. A write to the 8-bit data port clears all four flags at once.

Top module: `cmd_decoder`

## Requirements
- R1: After reset, the address, the command code, all four flags, the register strobe and every register read back as zero, so the legacy mode is active.
- R2: A control word that arrives while no second half is expected loads address bits 13:0 from word bits 13:0 and keeps address bits 15:14.
- R3: That same first-half word loads command bits 1:0 from word bits 15:14 and keeps command bits 5:2.
- R4: A first-half word with bits 15:14 equal to binary 10 is a register write, with index in word bits 12:8 and data in word bits 7:0. When accepted, the register takes the data and regWrStb pulses for one cycle in the cycle after the write, carrying that index and data.
- R5: In legacy mode (register 1 bit 2 clear), a register write whose index is 11 or higher is ignored: there is no strobe and the register file is unchanged.
- R6: In extended mode (register 1 bit 2 set), indices 0 to 23 are accepted and indices 24 to 31 are ignored.
- R7: A first-half word that is not a register write sets ctrlPending. A register-write word leaves ctrlPending clear.
- R8: A control word that arrives while ctrlPending is set is a second half. It loads address bits 15:14 from word bits 1:0 and command bits 5:2 from word bits 7:4, keeps the other bits, and clears ctrlPending. It never writes a register, whatever its top bits.
- R9: A write to the 8-bit data port clears ctrlPending, fetched, readPending and bytePending in the next cycle. The clear overrides any set request in the same cycle.
- R10: fetchSet, readPendSet and bytePendSet each set their own flag in the next cycle when no data-port write is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWord | input | 16 | Control word |
| byteWrEn | input | 1 | 8-bit data port write strobe |
| fetchSet | input | 1 | Sets the fetched flag |
| readPendSet | input | 1 | Sets the read-pending flag |
| bytePendSet | input | 1 | Sets the byte-pending flag |
| rdIdx | input | 5 | Register file read index |
| rdData | output | 8 | Register file read data (zero beyond the last register) |
| accAddr | output | 16 | Access address |
| cmdCode | output | 6 | Command code |
| mode5 | output | 1 | Extended mode enable (register 1 bit 2) |
| regWrStb | output | 1 | One-cycle pulse for an accepted register write |
| regWrIdx | output | 5 | Index of the accepted register write |
| regWrData | output | 8 | Data of the accepted register write |
| ctrlPending | output | 1 | A second control half is expected |
| fetched | output | 1 | Read data fetched flag |
| readPending | output | 1 | Read pending flag |
| bytePending | output | 1 | Byte pending flag |

## Verification
The properties assume that the inputs are steady and defined at each rising edge, and that a register strobe seen after reset comes from a write decoded with the mode bit of the previous cycle. They do not assume that control and data-port writes are exclusive, because the clear has a defined priority. The bench drives every input on the falling edge and reads the outputs one falling edge later. A fixed table of control words moves the address, command and pending state through first and second halves in both orders. Directed cases then cover the index limits in both modes, a second half that looks like a register write, and the clear-versus-set overlap.

// File: rtl/cmd_decoder_pkg.sv
package cmd_decoder_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 16;
  localparam int CD_W    = 6;
  localparam int IDX_W   = 5;
  localparam int DATA_W  = 8;
  localparam int LO_W    = ADDR_W - 2;   // address bits loaded by a first half
  localparam int CD_LO_W = 2;            // command bits loaded by a first half
  localparam int CD_HI_W = CD_W - CD_LO_W;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic loLoad;   // first-half load of low address / command bits
    logic hiLoad;   // second-half load of high address / command bits
    logic regWr;    // accepted register write
    logic pendSet;  // expect a second half
    logic pendClr;  // second half consumed
    logic flagClr;  // data-port byte write clears all flags
  } ctrlStrobes_t;
endpackage

// File: rtl/cmd_decoder_ctrl.sv
module cmd_decoder_ctrl
  import cmd_decoder_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11
) (
  input  logic              ctrlWrEn,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              byteWrEn,
  input  logic              pending,
  input  logic              mode5,
  output ctrlStrobes_t      strobes
);
  logic             isRegWord;
  logic [IDX_W-1:0] wordIdx;
  logic             idxInRange;
  logic             firstHalf;

  assign wordIdx   = ctrlWord[IDX_W+7:8];
  assign isRegWord = (ctrlWord[WORD_W-1 -: 2] == 2'b10);
  assign firstHalf = ctrlWrEn && !pending;

  always_comb begin
    if (mode5) idxInRange = (int'(wordIdx) < NUM_REGS);
    else       idxInRange = (int'(wordIdx) < LEGACY_REGS);
  end

  always_comb begin
    strobes         = '0;
    strobes.loLoad  = firstHalf;
    strobes.hiLoad  = ctrlWrEn && pending;
    strobes.pendClr = ctrlWrEn && pending;
    strobes.pendSet = firstHalf && !isRegWord;
    strobes.regWr   = firstHalf && isRegWord && idxInRange;
    strobes.flagClr = byteWrEn;
  end
endmodule

// File: rtl/cmd_decoder_dp.sv
module cmd_decoder_dp
  import cmd_decoder_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              fetchSet,
  input  logic              readPendSet,
  input  logic              bytePendSet,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] accAddr,
  output logic [CD_W-1:0]   cmdCode,
  output logic              mode5,
  output logic              regWrStb,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              ctrlPending,
  output logic              fetched,
  output logic              readPending,
  output logic              bytePending
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] wordData;

  assign wordIdx  = ctrlWord[IDX_W+7:8];
  assign wordData = ctrlWord[DATA_W-1:0];

  // address and command code
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accAddr <= '0;
      cmdCode <= '0;
    end else begin
      if (strobes.loLoad) begin
        accAddr[LO_W-1:0]    <= ctrlWord[LO_W-1:0];
        cmdCode[CD_LO_W-1:0] <= ctrlWord[WORD_W-1 -: CD_LO_W];
      end
      if (strobes.hiLoad) begin
        accAddr[ADDR_W-1:LO_W]    <= ctrlWord[ADDR_W-LO_W-1:0];
        cmdCode[CD_W-1:CD_LO_W]   <= ctrlWord[4 +: CD_HI_W];
      end
    end
  end

  // register file, one generated slot per register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regFile[g] <= '0;
      else if (strobes.regWr && (int'(wordIdx) == g)) regFile[g] <= wordData;
    end
  end

  assign mode5  = regFile[MODE_REG][MODE_BIT];
  assign rdData = (int'(rdIdx) < NUM_REGS) ? regFile[rdIdx] : '0;

  // register write echo
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regWrStb  <= 1'b0;
      regWrIdx  <= '0;
      regWrData <= '0;
    end else begin
      regWrStb <= strobes.regWr;
      if (strobes.regWr) begin
        regWrIdx  <= wordIdx;
        regWrData <= wordData;
      end
    end
  end

  // handshake flags: the byte-port clear wins over every set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlPending <= 1'b0;
      fetched     <= 1'b0;
      readPending <= 1'b0;
      bytePending <= 1'b0;
    end else if (strobes.flagClr) begin
      ctrlPending <= 1'b0;
      fetched     <= 1'b0;
      readPending <= 1'b0;
      bytePending <= 1'b0;
    end else begin
      if (strobes.pendClr)      ctrlPending <= 1'b0;
      else if (strobes.pendSet) ctrlPending <= 1'b1;
      if (fetchSet)    fetched     <= 1'b1;
      if (readPendSet) readPending <= 1'b1;
      if (bytePendSet) bytePending <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmd_decoder_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11,
  parameter int MODE_REG    = 1,
  parameter int MODE_BIT    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrlWrEn,
  input  logic [15:0] ctrlWord,
  input  logic        byteWrEn,
  input  logic        fetchSet,
  input  logic        readPendSet,
  input  logic        bytePendSet,
  input  logic [4:0]  rdIdx,
  output logic [7:0]  rdData,
  output logic [15:0] accAddr,
  output logic [5:0]  cmdCode,
  output logic        mode5,
  output logic        regWrStb,
  output logic [4:0]  regWrIdx,
  output logic [7:0]  regWrData,
  output logic        ctrlPending,
  output logic        fetched,
  output logic        readPending,
  output logic        bytePending
);
  ctrlStrobes_t strobes;

  cmd_decoder_ctrl #(
    .NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)
  ) ctrl_i (
    .ctrlWrEn(ctrlWrEn), .ctrlWord(ctrlWord), .byteWrEn(byteWrEn),
    .pending(ctrlPending), .mode5(mode5), .strobes(strobes)
  );

  cmd_decoder_dp #(
    .NUM_REGS(NUM_REGS), .MODE_REG(MODE_REG), .MODE_BIT(MODE_BIT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .ctrlWord(ctrlWord),
    .fetchSet(fetchSet), .readPendSet(readPendSet), .bytePendSet(bytePendSet),
    .rdIdx(rdIdx), .rdData(rdData), .accAddr(accAddr), .cmdCode(cmdCode),
    .mode5(mode5), .regWrStb(regWrStb), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .ctrlPending(ctrlPending), .fetched(fetched),
    .readPending(readPending), .bytePending(bytePending)
  );
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk #(
  parameter int NUM_REGS    = 24,
  parameter int LEGACY_REGS = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrlWrEn,
  input logic [15:0] ctrlWord,
  input logic        byteWrEn,
  input logic        fetchSet,
  input logic [15:0] accAddr,
  input logic [5:0]  cmdCode,
  input logic        mode5,
  input logic        regWrStb,
  input logic [4:0]  regWrIdx,
  input logic        ctrlPending,
  input logic        fetched,
  input logic        readPending,
  input logic        bytePending
);
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWrEn && !ctrlPending |=>
      accAddr[13:0] == $past(ctrlWord[13:0]) && accAddr[15:14] == $past(accAddr[15:14]));

  p_first_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWrEn && !ctrlPending |=>
      cmdCode[1:0] == $past(ctrlWord[15:14]) && cmdCode[5:2] == $past(cmdCode[5:2]));

  p_legacy_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regWrStb) && !$past(mode5) |-> int'(regWrIdx) < LEGACY_REGS);

  p_full_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regWrStb |-> int'(regWrIdx) < NUM_REGS);

  p_regword_no_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWrEn && !ctrlPending && ctrlWord[15:14] == 2'b10 |=> !ctrlPending);

  p_second_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWrEn && ctrlPending |=>
      !ctrlPending && !regWrStb && accAddr[15:14] == $past(ctrlWord[1:0]));

  p_byte_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byteWrEn |=> !ctrlPending && !fetched && !readPending && !bytePending);

  p_fetch_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetchSet && !byteWrEn |=> fetched);
endmodule

bind cmd_decoder cmd_decoder_chk #(
  .NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWord(ctrlWord),
  .byteWrEn(byteWrEn), .fetchSet(fetchSet), .accAddr(accAddr),
  .cmdCode(cmdCode), .mode5(mode5), .regWrStb(regWrStb), .regWrIdx(regWrIdx),
  .ctrlPending(ctrlPending), .fetched(fetched), .readPending(readPending),
  .bytePending(bytePending)
);

// File: tb/cmd_decoder_tb_top.sv
module cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {word, expected address, expected command (6 bits in 8), expected pending (in 8)}
  localparam logic [47:0] VECS [NVEC] = '{
    {16'h4123, 16'h0123, 8'h01, 8'h01},
    {16'h0092, 16'h8123, 8'h25, 8'h00},
    {16'hC3FF, 16'h83FF, 8'h27, 8'h01},
    {16'h0001, 16'h43FF, 8'h03, 8'h00},
    {16'h8A55, 16'h4A55, 8'h02, 8'h00},
    {16'h3FFF, 16'h7FFF, 8'h00, 8'h01},
    {16'hFFF3, 16'hFFFF, 8'h3C, 8'h00},
    {16'h8BAA, 16'hCBAA, 8'h3E, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrlWrEn = 1'b0, byteWrEn = 1'b0;
  logic fetchSet = 1'b0, readPendSet = 1'b0, bytePendSet = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic [4:0]  rdIdx = '0;
  logic [7:0]  rdData, regWrData;
  logic [15:0] accAddr;
  logic [5:0]  cmdCode;
  logic [4:0]  regWrIdx;
  logic mode5, regWrStb, ctrlPending, fetched, readPending, bytePending;
  int errors = 0, checks = 0;
  logic seenStb;
  logic [4:0] seenIdx;
  logic [7:0] seenData;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWord(ctrlWord),
    .byteWrEn(byteWrEn), .fetchSet(fetchSet), .readPendSet(readPendSet),
    .bytePendSet(bytePendSet), .rdIdx(rdIdx), .rdData(rdData),
    .accAddr(accAddr), .cmdCode(cmdCode), .mode5(mode5), .regWrStb(regWrStb),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .ctrlPending(ctrlPending),
    .fetched(fetched), .readPending(readPending), .bytePending(bytePending)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrlWrite(input logic [15:0] w);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWord = w;
    @(negedge clk); ctrlWrEn = 1'b0;
    seenStb = regWrStb; seenIdx = regWrIdx; seenData = regWrData;
  endtask

  task automatic readReg(input logic [4:0] i, output logic [7:0] d);
    rdIdx = i; #1; d = rdData;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(accAddr == 0 && cmdCode == 0, "R1 addr/cmd", {accAddr, 10'd0, cmdCode}, 0);
    check({ctrlPending, fetched, readPending, bytePending, regWrStb, mode5} == 0, "R1 flags",
          {ctrlPending, fetched, readPending, bytePending, regWrStb, mode5}, 0);
    readReg(5'd10, d);
    check(d == 0, "R1 reg10", d, 0);

    // table walk: R2 R3 R7 R8 over mixed first/second halves
    for (int i = 0; i < NVEC; i++) begin
      ctrlWrite(VECS[i][47:32]);
      check(accAddr == VECS[i][31:16], "R2/R8 addr", accAddr, VECS[i][31:16]);
      check(cmdCode == VECS[i][13:8], "R3/R8 cmd", cmdCode, VECS[i][13:8]);
      check(ctrlPending == VECS[i][0], "R7/R8 pending", ctrlPending, VECS[i][0]);
      if (i == 4) check(seenStb && seenIdx == 5'd10 && seenData == 8'h55, "R4 strobe",
                        {seenStb, seenIdx, seenData}, {1'b1, 5'd10, 8'h55});
      if (i == 7) check(!seenStb, "R5 idx11 legacy strobe", seenStb, 0);
    end
    readReg(5'd10, d);
    check(d == 8'h55, "R4 reg10 readback", d, 8'h55);
    readReg(5'd11, d);
    check(d == 8'h00, "R5 reg11 untouched", d, 0);
    @(negedge clk);
    check(!regWrStb, "R4 strobe one cycle", regWrStb, 0);

    // R6 extended mode
    ctrlWrite(16'h8104);
    check(mode5 == 1'b1, "R6 mode enable", mode5, 1);
    ctrlWrite(16'h9777);
    readReg(5'd23, d);
    check(seenStb && seenIdx == 5'd23 && d == 8'h77, "R6 idx23 accepted", {seenStb, seenIdx, d}, {1'b1, 5'd23, 8'h77});
    ctrlWrite(16'h9888);
    check(!seenStb, "R6 idx24 ignored strobe", seenStb, 0);
    ctrlWrite(16'h8B12);
    readReg(5'd11, d);
    check(d == 8'h12, "R6 idx11 now accepted", d, 8'h12);

    // R8 second half that looks like a register write
    ctrlWrite(16'h0000);
    check(ctrlPending, "R7 pending set", ctrlPending, 1);
    ctrlWrite(16'h8A66);
    readReg(5'd10, d);
    check(!seenStb && d == 8'h55, "R8 no register write", {seenStb, d}, {1'b0, 8'h55});
    check(accAddr[15:14] == 2'b10 && !ctrlPending, "R8 high addr", {accAddr, 7'd0, ctrlPending}, {16'h8000, 8'h00});

    // R10 flag sets, R9 clear
    @(negedge clk); fetchSet = 1; readPendSet = 1; bytePendSet = 1;
    @(negedge clk); fetchSet = 0; readPendSet = 0; bytePendSet = 0;
    check(fetched && readPending && bytePending, "R10 flags set",
          {fetched, readPending, bytePending}, 3'b111);
    ctrlWrite(16'h0123);
    check(ctrlPending, "R9 pending before clear", ctrlPending, 1);
    @(negedge clk); byteWrEn = 1;
    @(negedge clk); byteWrEn = 0;
    check({ctrlPending, fetched, readPending, bytePending} == 0, "R9 byte clear",
          {ctrlPending, fetched, readPending, bytePending}, 0);
    @(negedge clk); byteWrEn = 1; fetchSet = 1; bytePendSet = 1;
    @(negedge clk); byteWrEn = 0; fetchSet = 0; bytePendSet = 0;
    check(!fetched && !bytePending, "R9 clear beats set", {fetched, bytePending}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule